// File: doc/BRIEF.md
# Wrapped Phase-Difference Frequency Detector

This block sits between a phase estimator and a numerically controlled oscillator inside an all-digital tracking loop. Each time the estimator produces a new phase-error estimate, the block compares it with the estimate before it. It folds the change back into one turn, so that a crossing of the ±π seam is not taken for a large jump. The folded change is divided by an attenuation factor of ten, rounding toward minus infinity. The result is the per-window frequency correction. A positive change means the oscillator lags and must speed up. A negative change means it must slow down.

The correction is summed into a saturating accumulator, and the accumulator value is the oscillator's frequency control word. A controller can freeze the accumulator while it gathers the wrapped differences for averaging, because the differences still reach the outputs during a freeze. It can also overwrite the accumulator with a coarse offset in one step. Phase is coded as a two's-complement fraction of π: a `PH_W`-bit value `p` means `p·π/2^(PH_W-1)`, so with the defaults π corresponds to 2048.

Top module: `wrapped_phase_freq_det`

## Requirements
- R1: While reset is asserted and after its release, `diff_valid` is 0 and `freq_word`, `diff_out` and `omega_out` are 0.
- R2: The first accepted `phase_valid` after reset only stores the phase: no `diff_valid` pulse follows and `freq_word` keeps its value.
- R3: For every later accepted sample, `diff_out` one cycle later equals current minus previous phase, when that raw value lies in [−π, π] (−2048 to 2048 at defaults).
- R4: A raw difference below −π (less than −2048) is reported with 2π (4096) added.
- R5: A raw difference above π (greater than 2048) is reported with 2π subtracted; exactly +π is reported unchanged as +2048.
- R6: `omega_out` equals floor(`diff_out` / 10), so a difference in [0, π) gives a value ≥ 0 and any negative difference gives a value < 0.
- R7: On each update that is neither frozen nor loaded, `freq_word` becomes the previous word plus `omega_out`, clamped to the signed `ACC_W`-bit range (−524288 to 524287 at defaults).
- R8: While `freeze` is high, `freq_word` holds its value, yet `diff_valid`, `diff_out` and `omega_out` still update.
- R9: `load` writes `load_value` into `freq_word` on the next edge, with or without `phase_valid`, and takes priority over both update and freeze.
- R10: `diff_valid` is high for exactly one cycle after each accepted sample other than the first one, and it is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_valid | input | 1 | A new phase estimate is on `phase_in` |
| phase_in | input | PH_W | Signed phase estimate, π = 2^(PH_W-1) |
| freeze | input | 1 | Hold the accumulator; differences still reported |
| load | input | 1 | Overwrite the accumulator with `load_value` |
| load_value | input | ACC_W | Signed coarse frequency word |
| diff_valid | output | 1 | `diff_out` and `omega_out` hold a new result |
| diff_out | output | PH_W+1 | Wrapped phase difference, signed |
| omega_out | output | PH_W+1 | Attenuated correction, signed |
| freq_word | output | ACC_W | Signed oscillator control word |

## Verification
The hardest states to reach from the ports are the accumulator rails, because a correction step is at most about π/10. Walking there through phase samples alone would take thousands of windows. The stimulus uses `load` to place the word a few counts below the positive rail, or above the negative rail, and then applies one large difference of the needed sign to drive it into the clamp. The seam cases are reached by alternating samples near +π and −π, which produces both fold directions, together with a step of exactly +π.

// File: rtl/wpfd_pkg.sv
package wpfd_pkg;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/wpfd_wrap.sv
module wpfd_wrap #(
   parameter int PH_W = 12
) (
   input  logic signed [PH_W-1:0] cur_ph,
   input  logic signed [PH_W-1:0] prev_ph,
   output logic signed [PH_W:0]   wrapped
);
   localparam int XW = PH_W + 2;
   localparam logic signed [XW-1:0] HALF = XW'(1) <<< (PH_W - 1);
   localparam logic signed [XW-1:0] FULL = XW'(1) <<< PH_W;

   logic signed [XW-1:0] raw;
   logic signed [XW-1:0] fixed_v;

   always_comb begin
      raw = XW'(cur_ph) - XW'(prev_ph);
      if (raw < -HALF)
         fixed_v = raw + FULL;
      else if (raw > HALF)
         fixed_v = raw - FULL;
      else
         fixed_v = raw;
      wrapped = fixed_v[PH_W:0];
   end
endmodule

// File: rtl/wpfd_atten.sv
module wpfd_atten #(
   parameter int DW        = 13,
   parameter int ATTEN_DIV = 10
) (
   input  logic signed [DW-1:0] din,
   output logic signed [DW-1:0] dout
);
   import wpfd_pkg::*;

   generate
      if (is_pow2(ATTEN_DIV)) begin : g_shift
         localparam int SH = $clog2(ATTEN_DIV);
         // arithmetic shift already rounds toward minus infinity
         assign dout = din >>> SH;
      end else begin : g_divide
         localparam logic [DW:0] DIV   = (DW+1)'(ATTEN_DIV);
         localparam logic [DW:0] DIVM1 = (DW+1)'(ATTEN_DIV - 1);
         logic          neg;
         logic [DW:0]   mag;
         logic [DW:0]   quo;
         always_comb begin
            neg = din[DW-1];
            mag = neg ? (DW+1)'(-{din[DW-1], din}) : (DW+1)'({din[DW-1], din});
            quo = neg ? ((mag + DIVM1) / DIV) : (mag / DIV);
            dout = neg ? -($signed(quo[DW-1:0])) : $signed(quo[DW-1:0]);
         end
      end
   endgenerate
endmodule

// File: rtl/wpfd_accum.sv
module wpfd_accum #(
   parameter int ACC_W = 20,
   parameter int DW    = 13
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    step,
   input  logic                    freeze,
   input  logic                    load,
   input  logic signed [ACC_W-1:0] load_value,
   input  logic signed [DW-1:0]    omega,
   output logic signed [ACC_W-1:0] acc
);
   localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

   logic signed [ACC_W:0]   sum;
   logic signed [ACC_W-1:0] acc_next;

   always_comb begin
      sum = (ACC_W+1)'(acc) + (ACC_W+1)'(omega);
      if (sum[ACC_W] != sum[ACC_W-1])
         acc_next = sum[ACC_W] ? ACC_MIN : ACC_MAX;
      else
         acc_next = sum[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc <= '0;
      else if (load)
         acc <= load_value;
      else if (step && !freeze)
         acc <= acc_next;
   end

   assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !load) |=> $stable(acc));

   assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (acc == $past(load_value)));

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !freeze && !load && !omega[DW-1]) |=> (acc >= $past(acc)));

   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !freeze && !load && omega[DW-1]) |=> (acc < $past(acc) || acc == ACC_MIN));
endmodule

// File: rtl/wrapped_phase_freq_det.sv
module wrapped_phase_freq_det #(
   parameter int PH_W      = 12,
   parameter int ACC_W     = 20,
   parameter int ATTEN_DIV = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    phase_valid,
   input  logic signed [PH_W-1:0]  phase_in,
   input  logic                    freeze,
   input  logic                    load,
   input  logic signed [ACC_W-1:0] load_value,
   output logic                    diff_valid,
   output logic signed [PH_W:0]    diff_out,
   output logic signed [PH_W:0]    omega_out,
   output logic signed [ACC_W-1:0] freq_word
);
   localparam int DW = PH_W + 1;
   localparam logic signed [DW-1:0] PI_CODE = DW'(1) <<< (PH_W - 1);

   generate
      if (PH_W < 4) begin : g_bad_ph
         $error("PH_W must be at least 4");
      end
      if (ACC_W <= DW) begin : g_bad_acc
         $error("ACC_W must exceed PH_W+1");
      end
      if (ATTEN_DIV < 1 || ATTEN_DIV >= (1 << (PH_W - 1))) begin : g_bad_div
         $error("ATTEN_DIV out of range");
      end
   endgenerate

   logic signed [PH_W-1:0] prev_q;
   logic                   have_prev_q;
   logic signed [DW-1:0]   wrapped_c;
   logic signed [DW-1:0]   omega_c;
   logic                   step;

   assign step = phase_valid && have_prev_q;

   wpfd_wrap #(.PH_W(PH_W)) u_wrap (
      .cur_ph  (phase_in),
      .prev_ph (prev_q),
      .wrapped (wrapped_c)
   );

   wpfd_atten #(.DW(DW), .ATTEN_DIV(ATTEN_DIV)) u_atten (
      .din  (wrapped_c),
      .dout (omega_c)
   );

   wpfd_accum #(.ACC_W(ACC_W), .DW(DW)) u_accum (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (step),
      .freeze     (freeze),
      .load       (load),
      .load_value (load_value),
      .omega      (omega_c),
      .acc        (freq_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q      <= '0;
         have_prev_q <= 1'b0;
         diff_valid  <= 1'b0;
         diff_out    <= '0;
         omega_out   <= '0;
      end else begin
         diff_valid <= step;
         if (phase_valid) begin
            prev_q      <= phase_in;
            have_prev_q <= 1'b1;
         end
         if (step) begin
            diff_out  <= wrapped_c;
            omega_out <= omega_c;
         end
      end
   end

   assert_first_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_valid && !have_prev_q) |=> !diff_valid);

   assert_wrap_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      diff_valid |-> (diff_out >= -PI_CODE && diff_out <= PI_CODE));

   assert_omega_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
      diff_valid |-> (diff_out[DW-1] == omega_out[DW-1]));

   assert_pulse_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      diff_valid |-> $past(phase_valid));
endmodule

// File: tb/tb_wrapped_phase_freq_det.sv
module tb_wrapped_phase_freq_det;
   localparam int PH_W  = 12;
   localparam int ACC_W = 20;
   localparam int DIVV  = 10;
   localparam int HALF  = 2048;
   localparam int FULL  = 4096;
   localparam int AMAX  = 524287;
   localparam int AMIN  = -524288;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic phase_valid = 1'b0;
   logic signed [PH_W-1:0] phase_in = '0;
   logic freeze = 1'b0;
   logic load = 1'b0;
   logic signed [ACC_W-1:0] load_value = '0;
   logic diff_valid;
   logic signed [PH_W:0] diff_out;
   logic signed [PH_W:0] omega_out;
   logic signed [ACC_W-1:0] freq_word;

   int checks = 0;
   int failures = 0;
   int m_prev = 0;
   bit m_have = 1'b0;
   int m_acc = 0;

   int    q_d[$];
   int    q_om[$];
   int    q_fw[$];
   string q_req[$];

   always #5 clk = ~clk;

   wrapped_phase_freq_det #(.PH_W(PH_W), .ACC_W(ACC_W), .ATTEN_DIV(DIVV)) dut (
      .clk(clk), .rst_n(rst_n), .phase_valid(phase_valid), .phase_in(phase_in),
      .freeze(freeze), .load(load), .load_value(load_value),
      .diff_valid(diff_valid), .diff_out(diff_out), .omega_out(omega_out),
      .freq_word(freq_word)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int fdiv(input int v);
      return (v >= 0) ? v / DIVV : -((-v + DIVV - 1) / DIVV);
   endfunction

   // one cycle of stimulus; model computes the expectation before the edge
   task automatic send(input bit vld, input int ph, input bit frz, input bit ld,
                       input int ldv, input string req);
      int d;
      int om;
      @(negedge clk);
      phase_valid = vld;
      phase_in    = PH_W'(ph);
      freeze      = frz;
      load        = ld;
      load_value  = ACC_W'(ldv);
      if (vld && m_have) begin
         d = ph - m_prev;
         if (d < -HALF) d = d + FULL;
         else if (d > HALF) d = d - FULL;
         om = fdiv(d);
         if (ld) m_acc = ldv;
         else if (!frz) begin
            m_acc = m_acc + om;
            if (m_acc > AMAX) m_acc = AMAX;
            if (m_acc < AMIN) m_acc = AMIN;
         end
         q_d.push_back(d);
         q_om.push_back(om);
         q_fw.push_back(m_acc);
         q_req.push_back(req);
      end else if (ld) begin
         m_acc = ldv;
      end
      if (vld) begin
         m_prev = ph;
         m_have = 1'b1;
      end
      @(posedge clk);
      #1;
      phase_valid = 1'b0;
      freeze      = 1'b0;
      load        = 1'b0;
   endtask

   task automatic ph(input int p, input string req);
      send(1'b1, p, 1'b0, 1'b0, 0, req);
   endtask

   // monitor: scoreboard pop and compare
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && diff_valid) begin
            if (q_d.size() == 0) begin
               chk(1'b0, "R10 unexpected diff_valid", 1, 0);
            end else begin
               int ed;
               int eo;
               int ef;
               string r;
               ed = q_d.pop_front();
               eo = q_om.pop_front();
               ef = q_fw.pop_front();
               r  = q_req.pop_front();
               chk(int'(diff_out) == ed, {r, " diff"}, int'(diff_out), ed);
               chk(int'(omega_out) == eo, "R6 omega", int'(omega_out), eo);
               chk(int'(freq_word) == ef, {r, " word"}, int'(freq_word), ef);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(diff_valid == 1'b0, "R1 valid in reset", int'(diff_valid), 0);
      chk(freq_word == '0, "R1 word in reset", int'(freq_word), 0);
      rst_n = 1'b1;
      m_have = 1'b0;
      m_acc = 0;
      @(negedge clk);
      chk(diff_out == '0 && omega_out == '0, "R1 outputs after reset", int'(diff_out), 0);
   endtask

   initial begin
      do_reset();
      // R2: first sample only primes
      ph(100, "R2");
      @(negedge clk);
      chk(diff_valid == 1'b0, "R2 no pulse", int'(diff_valid), 0);
      chk(freq_word == '0, "R2 word kept", int'(freq_word), 0);
      // R3/R6/R7 in-range steps of both signs
      ph(400, "R3");
      ph(200, "R3");
      ph(203, "R3");
      ph(200, "R6");
      send(1'b0, 0, 1'b0, 1'b0, 0, "R10");
      send(1'b0, 0, 1'b0, 1'b0, 0, "R10");
      ph(2000, "R3");
      // seam crossings
      ph(-2000, "R4");
      ph(2000, "R5");
      ph(-2048, "R4");
      ph(0, "R5 exact pi");
      ph(-2048, "R3 exact -pi");
      // R8 freeze keeps word, still reports
      send(1'b1, 500, 1'b1, 1'b0, 0, "R8");
      send(1'b1, 900, 1'b1, 1'b0, 0, "R8");
      // R9 load without valid
      send(1'b0, 0, 1'b0, 1'b1, AMAX - 7, "R9");
      @(negedge clk);
      chk(int'(freq_word) == AMAX - 7, "R9 load idle", int'(freq_word), AMAX - 7);
      // R7 positive clamp
      ph(2047, "R7 clamp hi");
      ph(2047, "R7 hold at rail");
      // R9 load with valid and freeze both present
      send(1'b1, 1000, 1'b1, 1'b1, AMIN + 5, "R9");
      // R7 negative clamp
      ph(-500, "R7 clamp lo");
      ph(-1900, "R7 lo rail");
      // reset mid-run, then priming again
      do_reset();
      ph(-1000, "R2");
      @(negedge clk);
      chk(diff_valid == 1'b0, "R2 no pulse again", int'(diff_valid), 0);
      ph(1000, "R3");
      ph(-1000, "R3");
      repeat (3) @(negedge clk);
      chk(q_d.size() == 0, "R10 all results seen", q_d.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule